// File: doc/BRIEF.md
# HALT-Triggered Sleep Clock Controller

This block produces the processor clock and cuts its rate while the CPU sits idle. When the core signals that it has executed a HALT, and the power configuration register has sleep enabled, the controller moves the processor clock to a sleep rate. The sleep rate either stops the clock or divides it by 2, 4 or 8. A divided rate suits a CPU with dynamic logic, which needs a running clock. The stopped setting suits a fully static CPU only.

The processor clock is a registered square wave made from the source clock. At full speed it has a period of two source cycles. An interrupt, an NMI or any other wake request ends sleep and brings back the full-speed clock. Clearing the enable bit while asleep does the same. Every change of rate first drives the clock low, so the processor never sees a pulse shorter than a full-speed half period.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset the processor clock is low. Once reset is released it runs at full speed: a period of 2 source cycles, high for 1 of them.
- R2: A one-cycle HALT strobe enters sleep only when bit 7 of the power configuration register is 1. The sleep rate is then taken from bits 1:0 of the same register.
- R3: While asleep with rate code 01, 10 or 11, the processor clock period is 4, 8 or 16 source cycles. Each high and each low phase is half the period.
- R4: While asleep with rate code 00, the processor clock is held low.
- R5: A HALT strobe while bit 7 is 0 has no effect: the clock keeps its full-speed period of 2 cycles.
- R6: A wake request ends sleep. If the request is sampled at source edge k, the clock is low after edge k+1 and high after edge k+2, and it runs at full speed from then on.
- R7: Clearing bit 7 while asleep ends sleep with the same timing as R6.
- R8: Every change of clock rate, including a change of the rate code while asleep, drives the processor clock low at the same edge. The first pulse at the new rate has the full high width of that rate.
- R9: A wake request in the same cycle as a HALT strobe takes priority, so the block does not enter sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | One-cycle strobe: the CPU has executed a HALT |
| wake_i | input | 1 | Wake request: interrupt, NMI or reset |
| pwr_cfg_i | input | REG_W (8) | Power configuration register: bit 7 sleep enable, bits 1:0 sleep rate |
| cpu_clk_o | output | 1 | Processor clock |

## Verification
Inputs are driven between source edges and outputs are sampled at the falling source edge. Each sample therefore shows the value that the preceding rising edge registered. Sleep state is registered one edge after a HALT strobe, and the new rate takes hold on the edge after that. Period measurements start only after that settling window and after at least one complete pulse. After a wake request or a cleared enable bit, the bench counts edges exactly: the clock must read low one edge after the sampling edge and high two edges after it. The bench then measures a full-speed period. The bound assertions check the same latencies, using the configuration held stable across the window.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;

    localparam int PCFG_W     = 8;
    localparam int PCFG_EN    = 7;
    localparam int PCFG_RATE  = 0;
    localparam int RATE_W     = 2;
    localparam int MAX_HALF   = 8;
    localparam int HCNT_W     = $clog2(MAX_HALF);

    typedef enum logic [2:0] {
        M_FULL = 3'd0,
        M_DIV2 = 3'd1,
        M_DIV4 = 3'd2,
        M_DIV8 = 3'd3,
        M_STOP = 3'd4
    } clk_mode_e;

    function automatic clk_mode_e rate_to_mode(input logic [RATE_W-1:0] code);
        case (code)
            2'b00:   rate_to_mode = M_STOP;
            2'b01:   rate_to_mode = M_DIV2;
            2'b10:   rate_to_mode = M_DIV4;
            default: rate_to_mode = M_DIV8;
        endcase
    endfunction

    // last count of a half period (half length minus one)
    function automatic logic [HCNT_W-1:0] half_last(input clk_mode_e m);
        logic [HCNT_W:0] len;
        case (m)
            M_DIV2:  len = (HCNT_W+1)'(2);
            M_DIV4:  len = (HCNT_W+1)'(4);
            M_DIV8:  len = (HCNT_W+1)'(8);
            default: len = (HCNT_W+1)'(1);
        endcase
        half_last = HCNT_W'(len - 1'b1);
    endfunction

endpackage

// File: rtl/sleep_ctl.sv
module sleep_ctl
    import sleep_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              wake,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    output clk_mode_e         tgt_mode
);

    logic sleep_q;

    // wake and a cleared enable both win over HALT
    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
        end else if (wake || !enable) begin
            sleep_q <= 1'b0;
        end else if (halt) begin
            sleep_q <= 1'b1;
        end
    end

    always_comb begin
        tgt_mode = sleep_q ? rate_to_mode(rate) : M_FULL;
    end

endmodule

// File: rtl/clk_div_gen.sv
module clk_div_gen
    import sleep_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clk_mode_e tgt_mode,
    output clk_mode_e cur_mode,
    output logic      clk_out
);

    logic [HCNT_W-1:0] cnt_q;
    logic              clk_q;
    clk_mode_e         mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_FULL;
            clk_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (tgt_mode != mode_q) begin
            // switch only through a low phase
            mode_q <= tgt_mode;
            clk_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (mode_q == M_STOP) begin
            clk_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (cnt_q == half_last(mode_q)) begin
            clk_q  <= ~clk_q;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign cur_mode = mode_q;
    assign clk_out  = clk_q;

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import sleep_clk_pkg::*;
#(
    parameter int REG_W    = PCFG_W,
    parameter int EN_BIT   = PCFG_EN,
    parameter int RATE_LSB = PCFG_RATE
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             halt_i,
    input  logic             wake_i,
    input  logic [REG_W-1:0] pwr_cfg_i,
    output logic             cpu_clk_o
);

    clk_mode_e tgt_mode;
    clk_mode_e cur_mode;

    sleep_ctl u_ctl (
        .clk      (clk_src),
        .rst      (rst),
        .halt     (halt_i),
        .wake     (wake_i),
        .enable   (pwr_cfg_i[EN_BIT]),
        .rate     (pwr_cfg_i[RATE_LSB +: RATE_W]),
        .tgt_mode (tgt_mode)
    );

    clk_div_gen u_gen (
        .clk      (clk_src),
        .rst      (rst),
        .tgt_mode (tgt_mode),
        .cur_mode (cur_mode),
        .clk_out  (cpu_clk_o)
    );

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk
    import sleep_clk_pkg::*;
#(
    parameter int REG_W    = PCFG_W,
    parameter int EN_BIT   = PCFG_EN,
    parameter int RATE_LSB = PCFG_RATE
) (
    input logic             clk_src,
    input logic             rst,
    input logic             halt_i,
    input logic             wake_i,
    input logic [REG_W-1:0] pwr_cfg_i,
    input logic             cpu_clk_o,
    input clk_mode_e        cur_mode
);

    // R2
    sleep_entry_chk: assert property (@(posedge clk_src) disable iff (rst)
        (halt_i && pwr_cfg_i[EN_BIT] && !wake_i) ##1 (!wake_i && $stable(pwr_cfg_i))
        |=> (cur_mode == rate_to_mode(pwr_cfg_i[RATE_LSB +: RATE_W])));

    // R4
    stop_low_chk: assert property (@(posedge clk_src) disable iff (rst)
        (cur_mode == M_STOP) |-> !cpu_clk_o);

    // R5
    disabled_full_chk: assert property (@(posedge clk_src) disable iff (rst)
        ($past(!pwr_cfg_i[EN_BIT]) && !pwr_cfg_i[EN_BIT]) |=> (cur_mode == M_FULL));

    // R6
    wake_exit_chk: assert property (@(posedge clk_src) disable iff (rst)
        wake_i |-> ##2 (cur_mode == M_FULL));

    // R8
    switch_low_chk: assert property (@(posedge clk_src) disable iff (rst)
        !$stable(cur_mode) |-> !cpu_clk_o);

    // R9
    wake_priority_chk: assert property (@(posedge clk_src) disable iff (rst)
        (halt_i && wake_i && $past(cur_mode == M_FULL)) |=> ##1 (cur_mode == M_FULL));

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk #(
    .REG_W    (REG_W),
    .EN_BIT   (EN_BIT),
    .RATE_LSB (RATE_LSB)
) i_chk (
    .clk_src   (clk_src),
    .rst       (rst),
    .halt_i    (halt_i),
    .wake_i    (wake_i),
    .pwr_cfg_i (pwr_cfg_i),
    .cpu_clk_o (cpu_clk_o),
    .cur_mode  (cur_mode)
);

// File: tb/test_sleep_clk_ctrl.sv
module test_sleep_clk_ctrl;

    logic       clk_src = 1'b0;
    logic       rst     = 1'b1;
    logic       halt_i  = 1'b0;
    logic       wake_i  = 1'b0;
    logic [7:0] pwr_cfg_i = 8'h00;
    logic       cpu_clk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk_src = ~clk_src;

    sleep_clk_ctrl i_sleep_clk_ctrl (
        .clk_src   (clk_src),
        .rst       (rst),
        .halt_i    (halt_i),
        .wake_i    (wake_i),
        .pwr_cfg_i (pwr_cfg_i),
        .cpu_clk_o (cpu_clk_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_src);
        rst = 1'b1; halt_i = 1'b0; wake_i = 1'b0;
        repeat (3) @(negedge clk_src);
        check(cpu_clk_o == 1'b0, "R1 reset low", int'(cpu_clk_o), 0);
        rst = 1'b0;
    endtask

    // period and high width in source cycles, sampled at falling source edges
    task automatic measure(output int per, output int hi);
        logic prev;
        bit   found;
        per = -1; hi = 0; found = 0;
        prev = cpu_clk_o;
        for (int i = 0; i < 40 && !found; i++) begin
            @(negedge clk_src);
            if (!prev && cpu_clk_o) found = 1;
            prev = cpu_clk_o;
        end
        if (found) begin
            hi = 1;
            for (int i = 1; i <= 40; i++) begin
                @(negedge clk_src);
                if (!prev && cpu_clk_o) begin
                    per = i;
                    break;
                end
                if (cpu_clk_o) hi++;
                prev = cpu_clk_o;
            end
        end
    endtask

    task automatic pulse_halt(input bit with_wake);
        @(negedge clk_src);
        halt_i = 1'b1; wake_i = with_wake;
        @(negedge clk_src);
        halt_i = 1'b0; wake_i = 1'b0;
    endtask

    // drive exit stimulus before edge k, then check edges k+1 and k+2
    task automatic exit_latency(input string req, input bit use_wake);
        @(negedge clk_src);
        if (use_wake) wake_i = 1'b1;
        else          pwr_cfg_i[7] = 1'b0;
        @(negedge clk_src);
        wake_i = 1'b0;
        @(negedge clk_src);
        check(cpu_clk_o == 1'b0, {req, " low at k+1"}, int'(cpu_clk_o), 0);
        @(negedge clk_src);
        check(cpu_clk_o == 1'b1, {req, " high at k+2"}, int'(cpu_clk_o), 1);
    endtask

    initial begin
        int per, hi;
        for (int en = 0; en < 2; en++) begin
            for (int code = 0; code < 4; code++) begin
                do_reset();
                measure(per, hi);
                check(per == 2 && hi == 1, "R1 full speed", per, 2);
                @(negedge clk_src);
                pwr_cfg_i = {en[0], 5'b0, code[1:0]};
                pulse_halt(1'b0);
                repeat (3) @(negedge clk_src);
                if (en == 0) begin
                    measure(per, hi);
                    check(per == 2 && hi == 1, "R5 halt ignored", per, 2);
                end else if (code == 0) begin
                    bit stayed_low = 1;
                    for (int i = 0; i < 24; i++) begin
                        @(negedge clk_src);
                        if (cpu_clk_o) stayed_low = 0;
                    end
                    check(stayed_low, "R4 stopped low", int'(!stayed_low), 0);
                    exit_latency("R6", 1'b1);
                    measure(per, hi);
                    check(per == 2 && hi == 1, "R6 full after wake", per, 2);
                end else begin
                    measure(per, hi);
                    check(per == (2 << code), "R3 period (R2 entry)", per, 2 << code);
                    check(hi == (1 << code), "R3 high width", hi, 1 << code);
                    exit_latency("R6", 1'b1);
                    measure(per, hi);
                    check(per == 2 && hi == 1, "R6 full after wake", per, 2);
                end
            end
        end

        // R7: clear enable while asleep at divide by 4
        do_reset();
        @(negedge clk_src);
        pwr_cfg_i = 8'h82;
        pulse_halt(1'b0);
        repeat (5) @(negedge clk_src);
        exit_latency("R7", 1'b0);
        measure(per, hi);
        check(per == 2 && hi == 1, "R7 full after disable", per, 2);

        // R9: wake together with HALT
        do_reset();
        @(negedge clk_src);
        pwr_cfg_i = 8'h83;
        pulse_halt(1'b1);
        repeat (3) @(negedge clk_src);
        measure(per, hi);
        check(per == 2 && hi == 1, "R9 wake wins", per, 2);

        // R8: rate change while high in divide by 8 forces low, then full width
        do_reset();
        @(negedge clk_src);
        pwr_cfg_i = 8'h83;
        pulse_halt(1'b0);
        repeat (4) @(negedge clk_src);
        for (int i = 0; i < 40 && !cpu_clk_o; i++) @(negedge clk_src);
        check(cpu_clk_o == 1'b1, "R8 found high phase", int'(cpu_clk_o), 1);
        pwr_cfg_i = 8'h81;
        @(negedge clk_src);
        @(negedge clk_src);
        check(cpu_clk_o == 1'b0, "R8 low after switch", int'(cpu_clk_o), 0);
        measure(per, hi);
        check(per == 4 && hi == 2, "R8 new rate full width", per, 4);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_src);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule